// File: doc/BRIEF.md
# Interrupt Distributor Register Block

The block gathers a bank of interrupt request lines, 32 per group with a configurable group count. It decides, for every CPU it serves, which request that CPU should take next. For each source, software programs an enable bit, a 4-bit priority, a trigger mode (level-high or rising-edge) and a mask of destination CPUs. All of this goes through a plain 32-bit register port with a write strobe and a combinational read path. A read-only description word tells software how many source groups and CPUs the instance was built with.

Each CPU gets a request line, plus the ID and priority of the best candidate for it. The best candidate is the eligible source with the smallest priority value, and the lowest ID wins a tie. A source is eligible when the global enable is on and the source is enabled, pending, not active and aimed at that CPU. The CPU interface drives two pulses per CPU. An acknowledge pulse turns the presented source from pending into active. An end-of-interrupt pulse, which carries an ID, returns that source to inactive.

Top module: `irq_distributor`

## Requirements
- R1: The description word at byte offset 0x004 reads N_GROUPS-1 in bits [4:0] and N_CPUS-1 in bits [7:5], with all other bits zero, and writes to it change nothing.
- R2: Writing to the set bank (0x100 + 4*g) enables the sources of group g whose data bit is 1. Writing to the clear bank (0x180 + 4*g) disables them. Zero bits leave the enable unchanged, and a read of either bank returns the current enable bits of the group.
- R3: The priority of source i sits in bits [7:4] of byte i%4 of the word at 0x400 + 4*(i/4). Bits [3:0] of every byte read as zero.
- R4: The trigger mode of source i uses bits [2*(i%16)+1 : 2*(i%16)] of the word at 0xC00 + 4*(i/16). Bit 1 of the pair selects rising-edge (11) over level-high (01). A read returns bit 0 of each pair as 1, and after reset every source is level-high.
- R5: The destination mask of source i is the low N_CPUS bits of byte i%4 of the word at 0x800 + 4*(i/4), with bit c meaning CPU c. Bits above N_CPUS in each byte read as zero.
- R6: Bit 0 of the control word at 0x000 is the global enable, and it resets to 0. While it is 0, no request line is high.
- R7: A level-high source is pending while its input is high and drops out one cycle after the input falls. After its end-of-interrupt, a source whose input is still high is presented again.
- R8: A rising-edge source becomes pending on a 0-to-1 input step and stays pending after the input falls. Its acknowledge clears the pending state, so after its end-of-interrupt it is not presented again until a new rising step arrives.
- R9: For each CPU, the presented source has the smallest priority value among enabled, pending, inactive sources aimed at that CPU. The lowest ID wins a tie. The request line, ID and priority outputs change in the cycle after the state they depend on.
- R10: An acknowledge pulse on CPU c while its request line is high makes the presented source active. An active source is presented to no CPU, and the next candidate appears on the following cycle.
- R11: An end-of-interrupt pulse on CPU c clears the active state of the source named by that CPU's end-of-interrupt ID, from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| src_i | input | 32*N_GROUPS | Interrupt request inputs |
| irq_o | output | N_CPUS | Request line per CPU |
| irq_id_o | output | N_CPUS*ID_W | Presented source ID per CPU |
| irq_prio_o | output | N_CPUS*4 | Presented priority per CPU |
| ack_i | input | N_CPUS | Acknowledge pulse per CPU |
| eoi_i | input | N_CPUS | End-of-interrupt pulse per CPU |
| eoi_id_i | input | N_CPUS*ID_W | ID carried with each end-of-interrupt |

## Verification
The bench uses the default build of one group of 32 sources and two CPUs. At that size the full acknowledge order over all 32 sources can be walked. With priorities (7*i+3) mod 16 every priority value occurs twice, so each tie is resolved by ID somewhere in the walk, and the bench then walks end-of-interrupt back over every source. Two CPUs are enough to show a source aimed at one CPU only, and a shared source leaving both CPUs at once. Every priority and target word of the map is written and read back.

// File: rtl/idd_pkg.sv
package idd_pkg;
  localparam int PRIO_W = 4;
  localparam int AW     = 12;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_DESC, RG_ENSET, RG_ENCLR, RG_PRIO, RG_TGT, RG_CFG
  } region_e;

  function automatic region_e decode(input logic [AW-1:0] a);
    if (a[11:10] == 2'b01) return RG_PRIO;
    if (a[11:10] == 2'b10) return RG_TGT;
    if (a[11:10] == 2'b11) return RG_CFG;
    if (a[11:7] == 5'b00010) return RG_ENSET;
    if (a[11:7] == 5'b00011) return RG_ENCLR;
    if (a[11:2] == 10'd0) return RG_CTRL;
    if (a[11:2] == 10'd1) return RG_DESC;
    return RG_NONE;
  endfunction
endpackage

// File: rtl/idd_regs.sv
module idd_regs
  import idd_pkg::*;
#(
  parameter int N_GROUPS = 1,
  parameter int N_CPUS   = 2,
  localparam int NSRC    = 32 * N_GROUPS,
  localparam int SW      = $clog2(NSRC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                ctrl_en_o,
  output logic [NSRC-1:0]     en_o,
  output logic [NSRC-1:0]     edge_o,
  output logic [PRIO_W-1:0]   prio_o [NSRC],
  output logic [N_CPUS-1:0]   tgt_o  [NSRC]
);
  region_e rg;
  logic                ctrl_q;
  logic [NSRC-1:0]     en_q, edge_q;
  logic [PRIO_W-1:0]   prio_q [NSRC];
  logic [N_CPUS-1:0]   tgt_q  [NSRC];

  assign rg = decode(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 1'b0;
      en_q   <= '0;
      edge_q <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        tgt_q[i]  <= '0;
      end
    end else if (we_i) begin
      if (rg == RG_CTRL) ctrl_q <= wdata_i[0];
      for (int i = 0; i < NSRC; i++) begin
        if (rg == RG_ENSET && int'(addr_i[6:2]) == i / 32 && wdata_i[i % 32])
          en_q[i] <= 1'b1;
        if (rg == RG_ENCLR && int'(addr_i[6:2]) == i / 32 && wdata_i[i % 32])
          en_q[i] <= 1'b0;
        if (rg == RG_PRIO && int'(addr_i[9:2]) == i / 4)
          prio_q[i] <= wdata_i[(i % 4) * 8 + 4 +: PRIO_W];
        if (rg == RG_TGT && int'(addr_i[9:2]) == i / 4)
          tgt_q[i] <= wdata_i[(i % 4) * 8 +: N_CPUS];
        if (rg == RG_CFG && int'(addr_i[9:2]) == i / 16)
          edge_q[i] <= wdata_i[(i % 16) * 2 + 1];
      end
    end
  end

  always_comb begin
    int idx;
    rdata_o = '0;
    idx = 0;
    case (rg)
      RG_CTRL: rdata_o[0] = ctrl_q;
      RG_DESC: begin
        rdata_o[4:0] = 5'(N_GROUPS - 1);
        rdata_o[7:5] = 3'(N_CPUS - 1);
      end
      RG_ENSET, RG_ENCLR: begin
        for (int b = 0; b < 32; b++) begin
          idx = int'(addr_i[6:2]) * 32 + b;
          if (idx < NSRC) rdata_o[b] = en_q[SW'(idx)];
        end
      end
      RG_PRIO: begin
        for (int b = 0; b < 4; b++) begin
          idx = int'(addr_i[9:2]) * 4 + b;
          if (idx < NSRC) rdata_o[b*8+4 +: PRIO_W] = prio_q[SW'(idx)];
        end
      end
      RG_TGT: begin
        for (int b = 0; b < 4; b++) begin
          idx = int'(addr_i[9:2]) * 4 + b;
          if (idx < NSRC) rdata_o[b*8 +: N_CPUS] = tgt_q[SW'(idx)];
        end
      end
      RG_CFG: begin
        for (int b = 0; b < 16; b++) begin
          idx = int'(addr_i[9:2]) * 16 + b;
          if (idx < NSRC) begin
            rdata_o[2*b]   = 1'b1;
            rdata_o[2*b+1] = edge_q[SW'(idx)];
          end
        end
      end
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_en_o = ctrl_q;
  assign en_o      = en_q;
  assign edge_o    = edge_q;
  assign prio_o    = prio_q;
  assign tgt_o     = tgt_q;
endmodule

// File: rtl/idd_pend.sv
module idd_pend #(
  parameter int NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] edge_i,
  input  logic [NSRC-1:0] ack_set_i,
  input  logic [NSRC-1:0] eoi_clr_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] act_o
);
  logic [NSRC-1:0] src_q, pend_q, act_q, rise;

  assign rise = src_i & ~src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      src_q  <= src_i;
      // edge: sticky until acknowledged, a new rise wins; level: follows input
      pend_q <= (edge_i & ((pend_q & ~ack_set_i) | rise)) | (~edge_i & src_i);
      act_q  <= (act_q & ~eoi_clr_i) | ack_set_i;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/idd_arb.sv
module idd_arb
  import idd_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]   elig_i,
  input  logic [PRIO_W-1:0] prio_i [NSRC],
  output logic              valid_o,
  output logic [IDW-1:0]    id_o,
  output logic [PRIO_W-1:0] prio_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '1;
    // strict compare in ascending ID order keeps the lowest ID on a tie
    for (int i = 0; i < NSRC; i++) begin
      if (elig_i[i] && (!valid_o || prio_i[i] < prio_o)) begin
        valid_o = 1'b1;
        id_o    = IDW'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import idd_pkg::*;
#(
  parameter int N_GROUPS = 1,
  parameter int N_CPUS   = 2,
  localparam int NSRC    = 32 * N_GROUPS,
  localparam int ID_W    = $clog2(NSRC)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_we_i,
  input  logic [11:0]              bus_addr_i,
  input  logic [31:0]              bus_wdata_i,
  output logic [31:0]              bus_rdata_o,
  input  logic [NSRC-1:0]          src_i,
  output logic [N_CPUS-1:0]        irq_o,
  output logic [N_CPUS*ID_W-1:0]   irq_id_o,
  output logic [N_CPUS*4-1:0]      irq_prio_o,
  input  logic [N_CPUS-1:0]        ack_i,
  input  logic [N_CPUS-1:0]        eoi_i,
  input  logic [N_CPUS*ID_W-1:0]   eoi_id_i
);
  logic                      ctrl_en;
  logic [NSRC-1:0]           en_q, edge_q, pend_q, act_q;
  logic [NSRC-1:0]           ack_set, eoi_clr;
  logic [PRIO_W-1:0]         prio_q [NSRC];
  logic [N_CPUS-1:0]         tgt_q  [NSRC];
  logic [N_CPUS*NSRC-1:0]    tgt_flat;

  idd_regs #(.N_GROUPS(N_GROUPS), .N_CPUS(N_CPUS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .ctrl_en_o(ctrl_en), .en_o(en_q), .edge_o(edge_q), .prio_o(prio_q), .tgt_o(tgt_q)
  );

  idd_pend #(.NSRC(NSRC)) u_pend (
    .clk_i, .rst_ni, .src_i, .edge_i(edge_q),
    .ack_set_i(ack_set), .eoi_clr_i(eoi_clr), .pend_o(pend_q), .act_o(act_q)
  );

  always_comb begin
    for (int c = 0; c < N_CPUS; c++)
      for (int i = 0; i < NSRC; i++)
        tgt_flat[c*NSRC + i] = tgt_q[i][c];
  end

  for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
    logic [NSRC-1:0] elig;
    assign elig = {NSRC{ctrl_en}} & en_q & pend_q & ~act_q & tgt_flat[c*NSRC +: NSRC];
    idd_arb #(.NSRC(NSRC)) u_arb (
      .elig_i(elig), .prio_i(prio_q), .valid_o(irq_o[c]),
      .id_o(irq_id_o[c*ID_W +: ID_W]), .prio_o(irq_prio_o[c*4 +: 4])
    );
  end

  always_comb begin
    ack_set = '0;
    eoi_clr = '0;
    for (int c = 0; c < N_CPUS; c++) begin
      if (ack_i[c] && irq_o[c]) ack_set[irq_id_o[c*ID_W +: ID_W]] = 1'b1;
      if (eoi_i[c]) eoi_clr[eoi_id_i[c*ID_W +: ID_W]] = 1'b1;
    end
  end
endmodule

// File: rtl/idd_checker.sv
module idd_checker #(
  parameter int N_CPUS = 2,
  parameter int NSRC   = 32,
  parameter int IDW    = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_CPUS-1:0]      irq_o,
  input logic [N_CPUS*IDW-1:0]  irq_id_o,
  input logic [N_CPUS-1:0]      ack_i,
  input logic [N_CPUS-1:0]      eoi_i,
  input logic [N_CPUS*IDW-1:0]  eoi_id_i,
  input logic                   ctrl_en,
  input logic [NSRC-1:0]        en_q,
  input logic [NSRC-1:0]        act_q,
  input logic [N_CPUS*NSRC-1:0] tgt_flat
);
  for (genvar c = 0; c < N_CPUS; c++) begin : g_chk
    logic [IDW-1:0]  id_c, eoi_c;
    logic [NSRC-1:0] tcol;
    assign id_c  = irq_id_o[c*IDW +: IDW];
    assign eoi_c = eoi_id_i[c*IDW +: IDW];
    assign tcol  = tgt_flat[c*NSRC +: NSRC];

    AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_en |-> !irq_o[c]); // R6
    AST_WIN_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (en_q[id_c] && tcol[id_c])); // R9
    AST_WIN_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> !act_q[id_c]); // R10
    AST_ACK_ACTIVATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[c] && irq_o[c]) |=> act_q[$past(id_c)]); // R10
    AST_EOI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_i[c] && !(|ack_i)) |=> !act_q[$past(eoi_c)]); // R11
  end
endmodule

bind irq_distributor idd_checker #(.N_CPUS(N_CPUS), .NSRC(NSRC), .IDW(ID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .irq_id_o(irq_id_o),
  .ack_i(ack_i), .eoi_i(eoi_i), .eoi_id_i(eoi_id_i), .ctrl_en(ctrl_en),
  .en_q(en_q), .act_q(act_q), .tgt_flat(tgt_flat)
);

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
  localparam int NG = 1, NC = 2, NS = 32, IW = 5;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              we = 1'b0;
  logic [11:0]       addr = '0;
  logic [31:0]       wdata = '0, rdata;
  logic [NS-1:0]     src = '0;
  logic [NC-1:0]     irq, ack = '0, eoi = '0;
  logic [NC*IW-1:0]  irq_id, eoi_id = '0;
  logic [NC*4-1:0]   irq_prio;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_distributor #(.N_GROUPS(NG), .N_CPUS(NC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .src_i(src), .irq_o(irq), .irq_id_o(irq_id), .irq_prio_o(irq_prio),
    .ack_i(ack), .eoi_i(eoi), .eoi_id_i(eoi_id)
  );

  function automatic int pr(int i); return (i * 7 + 3) % 16; endfunction

  function automatic int best(logic [NS-1:0] avail);
    int b = -1;
    for (int i = 0; i < NS; i++)
      if (avail[i] && (b < 0 || pr(i) < pr(b))) b = i;
    return b;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_ack(int c);
    @(negedge clk); ack[c] = 1'b1;
    @(negedge clk); ack = '0;
  endtask

  task automatic pulse_eoi(int c, int id);
    @(negedge clk); eoi[c] = 1'b1; eoi_id[c*IW +: IW] = IW'(id);
    @(negedge clk); eoi = '0;
  endtask

  task automatic set_src(logic [NS-1:0] v);
    @(negedge clk); src = v;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w;
    logic [NS-1:0] held;
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(12'h000, d); chk("R6 ctrl reset", d, 32'h0);
    chk("R6 irq reset", 32'(irq), 32'h0);
    rd(12'h004, d); chk("R1 desc", d, 32'h20);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R1 desc write ignored", d, 32'h20);
    rd(12'hC00, d); chk("R4 cfg reset level", d, 32'h5555_5555);

    // enable banks
    wr(12'h100, 32'hA5A5_0F0F);
    rd(12'h100, d); chk("R2 set bank read", d, 32'hA5A5_0F0F);
    rd(12'h180, d); chk("R2 clear bank read", d, 32'hA5A5_0F0F);
    wr(12'h180, 32'h0000_000F);
    rd(12'h100, d); chk("R2 after clear", d, 32'hA5A5_0F00);
    wr(12'h100, 32'h0);
    rd(12'h180, d); chk("R2 zero set no effect", d, 32'hA5A5_0F00);
    wr(12'h180, 32'h0);
    rd(12'h100, d); chk("R2 zero clear no effect", d, 32'hA5A5_0F00);
    wr(12'h180, 32'hFFFF_FFFF);

    // priority and target maps: every word
    for (int k = 0; k < 8; k++) begin
      w = 32'h9C3A_5F17 ^ (32'h1111_1111 * 32'(k));
      wr(12'h400 + 12'(4 * k), w);
      rd(12'h400 + 12'(4 * k), d); chk("R3 prio readback", d, w & 32'hF0F0_F0F0);
      wr(12'h800 + 12'(4 * k), 32'hFFFF_FFFF);
      rd(12'h800 + 12'(4 * k), d); chk("R5 target readback", d, 32'h0303_0303);
    end

    // trigger configuration
    for (int k = 0; k < 2; k++) begin
      wr(12'hC00 + 12'(4 * k), 32'hFFFF_FFFF);
      rd(12'hC00 + 12'(4 * k), d); chk("R4 cfg all edge", d, 32'hFFFF_FFFF);
      wr(12'hC00 + 12'(4 * k), 32'hAAAA_AAAA);
      rd(12'hC00 + 12'(4 * k), d); chk("R4 cfg bit1 only", d, 32'hFFFF_FFFF);
      wr(12'hC00 + 12'(4 * k), 32'h0);
      rd(12'hC00 + 12'(4 * k), d); chk("R4 cfg level", d, 32'h5555_5555);
    end

    // program sweep priorities
    for (int k = 0; k < 8; k++) begin
      w = '0;
      for (int j = 0; j < 4; j++) w[j*8+4 +: 4] = 4'(pr(4 * k + j));
      wr(12'h400 + 12'(4 * k), w);
    end
    wr(12'h100, 32'hFFFF_FFFF);
    set_src('1);
    chk("R6 disabled no irq", 32'(irq), 32'h0);
    wr(12'h000, 32'h1);

    // full acknowledge order, alternating CPUs
    held = '1;
    for (int k = 0; k < NS; k++) begin
      b = best(held);
      chk("R9 cpu0 irq", 32'(irq[0]), 32'h1);
      chk("R9 cpu0 id", 32'(irq_id[0 +: IW]), 32'(b));
      chk("R9 cpu0 prio", 32'(irq_prio[3:0]), 32'(pr(b)));
      chk("R10 cpu1 id", 32'(irq_id[IW +: IW]), 32'(b));
      pulse_ack(k % 2);
      held[b] = 1'b0;
    end
    chk("R10 all active no irq", 32'(irq), 32'h0);

    // end-of-interrupt in ID order, level inputs still high
    for (int k = 0; k < NS; k++) begin
      pulse_eoi(k % 2, k);
      held[k] = 1'b1;
      chk("R11 eoi re-presents", 32'(irq_id[0 +: IW]), 32'(best(held)));
      chk("R7 level still high", 32'(irq[1]), 32'h1);
    end

    // global enable
    wr(12'h000, 32'h0);
    chk("R6 ctrl off", 32'(irq), 32'h0);
    wr(12'h000, 32'h1);
    chk("R6 ctrl on", 32'(irq), 32'h3);

    // targets and enables
    wr(12'h180, 32'hFFFF_FFFF);
    wr(12'h100, 32'h0010_0200);
    wr(12'h808, 32'h0202_0202);
    chk("R9 cpu0 untargeted skip", 32'(irq_id[0 +: IW]), 32'd20);
    chk("R9 cpu0 prio", 32'(irq_prio[3:0]), 32'(pr(20)));
    chk("R9 cpu1 best", 32'(irq_id[IW +: IW]), 32'd9);
    chk("R9 cpu1 prio", 32'(irq_prio[7:4]), 32'(pr(9)));
    wr(12'h808, 32'h0303_0303);

    // level drop
    wr(12'h180, 32'hFFFF_FFFF);
    wr(12'h100, 32'h0000_0010);
    chk("R7 level pending", 32'(irq_id[0 +: IW]), 32'd4);
    set_src('0);
    chk("R7 level drop", 32'(irq), 32'h0);

    // rising edge on source 3
    wr(12'h180, 32'hFFFF_FFFF);
    wr(12'h100, 32'h0000_0008);
    wr(12'hC00, 32'h0000_00C0);
    rd(12'hC00, d); chk("R4 src3 edge", d, 32'h5555_55D5);
    chk("R8 idle", 32'(irq), 32'h0);
    set_src(32'h8);
    chk("R8 rise pending", 32'(irq_id[0 +: IW]), 32'd3);
    chk("R8 rise irq", 32'(irq[0]), 32'h1);
    set_src(32'h0);
    chk("R8 sticky after fall", 32'(irq[0]), 32'h1);
    pulse_ack(0);
    chk("R10 acked", 32'(irq), 32'h0);
    pulse_eoi(0, 3);
    chk("R8 no re-present without rise", 32'(irq), 32'h0);
    set_src(32'h8);
    chk("R8 second rise", 32'(irq[1]), 32'h1);
    pulse_ack(1);
    pulse_eoi(1, 3);
    chk("R8 held high no re-present", 32'(irq), 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule